// File: doc/BRIEF.md
# Bipolar Stepper Excitation Sequencer

This block keeps the electrical angle of a two-phase bipolar stepping motor and turns it into a signed current-level code for each of the two windings. A step clock, arriving from outside the system clock domain, moves the angle one position per rising edge. A direction bit picks the rotation sense. A two-bit mode code picks one of three step resolutions: full step with both phases on, half step, and quarter step. The same code also provides a standby setting. The codes feed a downstream current-reference generator, and the bridge-enable output gates the power stage.

The angle is a 16-position counter. Each position is 22.5 electrical degrees. Quarter step moves one position per step, half step moves two and full step moves four, and all three resolutions share one home position at 45 degrees. Each phase code is a negative-sign bit plus a 3-bit level. A monitor output goes low whenever the angle sits at home. An angle-reset input or standby returns the angle to home.

Top module: `stepper_seq`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, the block is in standby: `standby`=1, `drv_en`=0, both magnitudes are 0, both sign bits are 0 and `home_n`=0.
- R2: `step_in` passes through a two-flop synchronizer. A step is taken on the clock edge where the synchronized input has been high for FILT_MIN consecutive cycles. A high pulse seen for fewer cycles has no effect. Exactly one step is taken per high period, and a falling edge moves nothing.
- R3: With `dir_fwd`=1 a step adds the step size to the angle index, and with `dir_fwd`=0 it subtracts it, wrapping modulo 16. Phase A follows sin(index x 22.5 deg) and phase B follows cos, so in forward rotation A lags B by 90 degrees and in reverse A leads B.
- R4: Mode code 00 is standby. On the first edge that samples 00 the angle returns to home (index 2) and `standby` becomes 1. While in standby, `drv_en`=0, both codes are zero and steps are ignored.
- R5: In quarter-step mode (code 11), the magnitude encodes |sin| or |cos| as 0=0%, 1=38%, 2=71%, 3=92% and 4=100%. The sign bit is 1 for a negative value and 0 for a zero magnitude.
- R6: In full-step mode (code 01) and half-step mode (code 10), every 71% level reads as 100%. A half step moves 2 positions and clears bit 0 of the new index. A full step moves 4 positions and forces the low two bits of the new index to 10.
- R7: `drv_en` equals `enable` AND not standby. `enable` has no effect on the angle or on the codes.
- R8: While `ang_rst` is high the angle is held at home, and a step that fires in the same cycle is discarded. The home codes are 71%/71% in quarter-step mode and 100%/100% in the other two modes, both positive.
- R9: `home_n` is 0 exactly when the angle index is 2.
- R10: A change between non-zero mode codes does not move the angle. The codes and the step size adopt the new mode on the next step or angle reset. Leaving standby adopts the new mode on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Asynchronous step clock; the rising edge advances the angle |
| dir_fwd | input | 1 | 1 = forward (index increments), 0 = reverse |
| mode_sel | input | 2 | 00 standby, 01 full step, 10 half step, 11 quarter step |
| enable | input | 1 | Bridge enable request |
| ang_rst | input | 1 | Holds the angle at home while high |
| pha_neg | output | 1 | Phase A negative-current flag |
| pha_mag | output | 3 | Phase A level code (0..4) |
| phb_neg | output | 1 | Phase B negative-current flag |
| phb_mag | output | 3 | Phase B level code (0..4) |
| drv_en | output | 1 | Bridge enable to the power stage |
| standby | output | 1 | High while the active mode is standby |
| home_n | output | 1 | Low when the angle is at home |

## Verification
A filtered step can fire on the same clock edge that an angle reset or a standby request is sampled. In that case the home load must win and the step must be lost, not queued. The bench provokes this by raising `ang_rst` for only the one edge on which the filter's FILT_MIN-th high sample lands. A behavioural model, which counts synchronized high samples with a queue, decides on every clock which event applies. The bench then compares the angle-dependent codes and the monitor against that model.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int ANG_W = 4;
  localparam logic [ANG_W-1:0] HOME_IDX = 4'd2;
  localparam int MAG_W = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_FULL = 2'b01,
    MODE_HALF = 2'b10,
    MODE_QTR  = 2'b11
  } stp_mode_e;

  // Next angle for one step in the given mode, with alignment applied.
  function automatic logic [ANG_W-1:0] next_angle(input logic [ANG_W-1:0] a,
                                                  input stp_mode_e m,
                                                  input logic fwd);
    logic [ANG_W-1:0] inc;
    logic [ANG_W-1:0] r;
    case (m)
      MODE_FULL: inc = ANG_W'(4);
      MODE_HALF: inc = ANG_W'(2);
      default:   inc = ANG_W'(1);
    endcase
    r = fwd ? a + inc : a - inc;
    if (m == MODE_HALF) r[0] = 1'b0;
    else if (m == MODE_FULL) r[1:0] = 2'b10;
    return r;
  endfunction

  // Level within a quadrant: rising follows the offset, falling mirrors it.
  function automatic logic [MAG_W-1:0] quad_level(input logic [1:0] off,
                                                  input logic rising);
    return rising ? {1'b0, off} : MAG_W'(4) - {1'b0, off};
  endfunction

  // Promote 71% to 100% outside quarter-step mode.
  function automatic logic [MAG_W-1:0] mode_level(input logic [MAG_W-1:0] lv,
                                                  input stp_mode_e m);
    return (m != MODE_QTR && lv == MAG_W'(2)) ? MAG_W'(4) : lv;
  endfunction
endpackage

// File: rtl/step_filter.sv
module step_filter #(
  parameter int FILT_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  output logic fire
);
  localparam int CNT_W = $clog2(FILT_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_MIN);
  localparam logic [CNT_W-1:0] CNT_ARM = CNT_W'(FILT_MIN - 1);

  logic sync1, sync2;
  logic [CNT_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= step_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (!sync2) run <= '0;
    else if (run != CNT_TOP) run <= run + 1'b1;
  end

  assign fire = sync2 && (run == CNT_ARM);

  // R2
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/angle_track.sv
module angle_track
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             dir_fwd,
  input  logic [1:0]       mode_sel,
  input  logic             ang_rst,
  output logic [ANG_W-1:0] angle,
  output stp_mode_e        act_mode
);
  stp_mode_e req_mode;
  logic      go_home;
  logic      do_step;
  logic      take_mode;

  assign req_mode  = stp_mode_e'(mode_sel);
  assign go_home   = (req_mode == MODE_OFF) || ang_rst;
  assign do_step   = fire && (act_mode != MODE_OFF) && !go_home;
  assign take_mode = fire || go_home || (act_mode == MODE_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) angle <= HOME_IDX;
    else if (go_home) angle <= HOME_IDX;
    else if (do_step) angle <= next_angle(angle, req_mode, dir_fwd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_mode <= MODE_OFF;
    else if (take_mode) act_mode <= req_mode;
  end

  // R8
  rst_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ang_rst |=> angle == HOME_IDX);
  // R4
  standby_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> (angle == HOME_IDX && act_mode == MODE_OFF));
  // R6
  full_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act_mode != MODE_OFF && mode_sel == 2'b01 && !ang_rst)
      |=> angle[1:0] == 2'b10);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !ang_rst && mode_sel != 2'b00) |=> $stable(angle));
endmodule

// File: rtl/phase_lut.sv
module phase_lut
  import stp_pkg::*;
(
  input  logic [ANG_W-1:0] angle,
  input  stp_mode_e        act_mode,
  output logic [1:0]       ph_neg,
  output logic [MAG_W-1:0] ph_mag [2]
);
  logic [1:0] quad;
  logic [1:0] off;
  assign quad = angle[3:2];
  assign off  = angle[1:0];

  // Phase 0 follows sine, phase 1 follows cosine.
  for (genvar p = 0; p < 2; p++) begin : g_phase
    logic             rising;
    logic             neg_raw;
    logic [MAG_W-1:0] lvl;
    if (p == 0) begin : g_sin
      assign rising  = !quad[0];
      assign neg_raw = quad[1];
    end else begin : g_cos
      assign rising  = quad[0];
      assign neg_raw = quad[1] ^ quad[0];
    end
    assign lvl = mode_level(quad_level(off, rising), act_mode);
    always_comb begin
      if (act_mode == MODE_OFF) begin
        ph_mag[p] = '0;
        ph_neg[p] = 1'b0;
      end else begin
        ph_mag[p] = lvl;
        ph_neg[p] = neg_raw && (lvl != '0);
      end
    end
  end
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stp_pkg::*;
#(
  parameter int FILT_MIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_in,
  input  logic       dir_fwd,
  input  logic [1:0] mode_sel,
  input  logic       enable,
  input  logic       ang_rst,
  output logic       pha_neg,
  output logic [2:0] pha_mag,
  output logic       phb_neg,
  output logic [2:0] phb_mag,
  output logic       drv_en,
  output logic       standby,
  output logic       home_n
);
  logic             step_fire;
  logic [ANG_W-1:0] angle;
  stp_mode_e        act_mode;
  logic [1:0]       ph_neg;
  logic [MAG_W-1:0] ph_mag [2];

  step_filter #(.FILT_MIN(FILT_MIN)) u_filt (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .fire(step_fire)
  );

  angle_track u_ang (
    .clk(clk), .rst_n(rst_n), .fire(step_fire), .dir_fwd(dir_fwd),
    .mode_sel(mode_sel), .ang_rst(ang_rst), .angle(angle), .act_mode(act_mode)
  );

  phase_lut u_lut (
    .angle(angle), .act_mode(act_mode), .ph_neg(ph_neg), .ph_mag(ph_mag)
  );

  assign pha_neg = ph_neg[0];
  assign pha_mag = ph_mag[0];
  assign phb_neg = ph_neg[1];
  assign phb_mag = ph_mag[1];
  assign standby = (act_mode == MODE_OFF);
  assign drv_en  = enable && !standby;
  assign home_n  = (angle != HOME_IDX);

  // R4
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> (!drv_en && pha_mag == 3'd0 && phb_mag == 3'd0));
  // R9
  home_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ang_rst |=> !home_n);
endmodule

// File: tb/stepper_seq_tb.sv
module stepper_seq_tb;
  localparam int FMIN = 3;

  logic clk = 0, rst_n = 0, step_in = 0, dir_fwd = 1, enable = 0, ang_rst = 0;
  logic [1:0] mode_sel = 2'b00;
  logic pha_neg, phb_neg, drv_en, standby, home_n;
  logic [2:0] pha_mag, phb_mag;

  int n_chk = 0, n_fail = 0;

  stepper_seq #(.FILT_MIN(FMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_fwd(dir_fwd),
    .mode_sel(mode_sel), .enable(enable), .ang_rst(ang_rst),
    .pha_neg(pha_neg), .pha_mag(pha_mag), .phb_neg(phb_neg), .phb_mag(phb_mag),
    .drv_en(drv_en), .standby(standby), .home_n(home_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  int m_ang = 2, m_act = 0, m_run = 0;
  bit hq[$] = '{0, 0};

  function automatic int lvl_of(real v);
    real a;
    a = (v < 0.0) ? -v : v;
    if (a < 0.2) return 0;
    if (a < 0.55) return 1;
    if (a < 0.8) return 2;
    if (a < 0.96) return 3;
    return 4;
  endfunction

  function automatic real ph_val(int idx, int ph);
    real th;
    th = idx * 22.5 * 3.14159265358979 / 180.0;
    return (ph == 0) ? $sin(th) : $cos(th);
  endfunction

  function automatic int exp_mag(int ph);
    int l;
    if (m_act == 0) return 0;
    l = lvl_of(ph_val(m_ang, ph));
    if (m_act != 3 && l == 2) l = 4;
    return l;
  endfunction

  function automatic int exp_neg(int ph);
    if (m_act == 0) return 0;
    return (ph_val(m_ang, ph) < -0.2) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    bit syn, pulse;
    int step, nxt;
    if (!rst_n) begin
      m_ang = 2; m_act = 0; m_run = 0; hq = '{0, 0};
    end else begin
      syn = hq.pop_front();
      hq.push_back(step_in);
      m_run = syn ? m_run + 1 : 0;
      pulse = syn && (m_run == FMIN);
      if (mode_sel == 0 || ang_rst) m_ang = 2;
      else if (pulse && m_act != 0) begin
        step = (mode_sel == 1) ? 4 : (mode_sel == 2) ? 2 : 1;
        nxt = dir_fwd ? m_ang + step : m_ang - step;
        nxt = (nxt + 16) % 16;
        if (mode_sel == 2) nxt = nxt - (nxt % 2);
        if (mode_sel == 1) nxt = nxt - (nxt % 4) + 2;
        m_ang = nxt;
      end
      if (pulse || ang_rst || mode_sel == 0 || m_act == 0) m_act = mode_sel;
    end
  end

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R5 pha_mag", pha_mag, exp_mag(0));
      chk("R5 phb_mag", phb_mag, exp_mag(1));
      chk("R3 pha_neg", pha_neg, exp_neg(0));
      chk("R3 phb_neg", phb_neg, exp_neg(1));
      chk("R9 home_n", home_n, (m_ang != 2) ? 1 : 0);
      chk("R4 standby", standby, (m_act == 0) ? 1 : 0);
      chk("R7 drv_en", drv_en, (enable && m_act != 0) ? 1 : 0);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int len);
    @(negedge clk) step_in = 1;
    wait_cyc(len);
    step_in = 0;
    wait_cyc(6);
  endtask

  task automatic codes(string tag, int an, int am, int bn, int bm);
    chk({tag, " A sign"}, pha_neg, an);
    chk({tag, " A mag"}, pha_mag, am);
    chk({tag, " B sign"}, phb_neg, bn);
    chk({tag, " B mag"}, phb_mag, bm);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    chk("R1 standby", standby, 1);
    chk("R1 drv_en", drv_en, 0);
    codes("R1", 0, 0, 0, 0);
    chk("R1 home_n", home_n, 0);
    rst_n = 1;
    wait_cyc(2);
    mode_sel = 2'b11; enable = 1;
    wait_cyc(3);
    codes("R8 quarter home", 0, 2, 0, 2);
    // R2: short pulse ignored
    pulse(2);
    codes("R2 short pulse", 0, 2, 0, 2);
    chk("R2 home_n", home_n, 0);
    // R3 forward one step -> index 3
    pulse(6);
    codes("R3 fwd", 0, 3, 0, 1);
    chk("R9 off home", home_n, 1);
    // R3 reverse to wrap: 3 -> 2 -> 1 -> 0 -> 15
    dir_fwd = 0;
    for (int i = 0; i < 4; i++) pulse(5);
    codes("R3 wrap idx15", 1, 1, 0, 3);
    // R8 angle reset
    @(negedge clk) ang_rst = 1;
    wait_cyc(2);
    ang_rst = 0;
    wait_cyc(1);
    codes("R8 after rst", 0, 2, 0, 2);
    // R10 mode change to half: angle and codes unchanged until step
    dir_fwd = 1;
    @(negedge clk) mode_sel = 2'b10;
    wait_cyc(3);
    codes("R10 pending", 0, 2, 0, 2);
    pulse(5);
    codes("R6 half idx4", 0, 4, 0, 0);
    // R6 full step: 4 -> 8 -> aligned 10
    @(negedge clk) mode_sel = 2'b01;
    pulse(5);
    codes("R6 full idx10", 1, 4, 1, 4);
    // R7 enable low gates bridge only
    @(negedge clk) enable = 0;
    wait_cyc(2);
    chk("R7 drv off", drv_en, 0);
    codes("R7 codes kept", 1, 4, 1, 4);
    enable = 1;
    // R8 collision: ang_rst on the exact firing edge
    @(negedge clk) mode_sel = 2'b11; step_in = 1;
    wait_cyc(4);
    ang_rst = 1;
    wait_cyc(1);
    ang_rst = 0;
    wait_cyc(3);
    step_in = 0;
    wait_cyc(4);
    codes("R8 collision", 0, 2, 0, 2);
    chk("R8 home_n", home_n, 0);
    // quarter-step sweep
    for (int i = 0; i < 18; i++) pulse(4 + (i % 3));
    // R4 standby
    @(negedge clk) mode_sel = 2'b00;
    wait_cyc(2);
    chk("R4 standby", standby, 1);
    codes("R4 zero", 0, 0, 0, 0);
    chk("R4 home", home_n, 0);
    pulse(5);
    chk("R4 steps ignored", home_n, 0);
    @(negedge clk) mode_sel = 2'b01;
    wait_cyc(2);
    codes("R10 leave standby", 0, 4, 0, 4);
    for (int i = 0; i < 5; i++) pulse(5);
    wait_cyc(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule